// File: doc/BRIEF.md
# 4PPM Infrared Frame Receiver

This block takes a serial infrared chip stream that has already been sampled at the chip rate. A strobe marks each valid chip. The block recovers the data bytes of pulse-position-modulated frames. While idle it hunts for an eight-chip start flag. Once the flag is found, the chip stream is cut into aligned four-chip symbols. Each symbol becomes a two-bit data pair, and the pairs are packed into bytes. The frame closes when two all-zero symbols arrive back to back.

At that moment the block also finishes its checks. These cover illegal symbols, a CRC-32 mismatch and a payload length outside the allowed range. The results are latched into a status register. A host reads the register, and a read strobe clears it. While the local transmitter is active, the receive path is held idle and ignores the line.

The controller has three states. HUNT waits for the start flag, and the transition START moves it to DATA. DATA decodes symbols, and the transition GAP takes it to ZERO when an all-zero symbol arrives. From ZERO, the transition STOP (a second all-zero symbol) closes the frame and returns to HUNT. The transition RESUME (any other symbol) goes back to DATA and flags an illegal symbol. The transition ABORT returns the controller to HUNT from any state while the transmitter is busy.

Top module: `irrx_4ppm`

## Requirements
- R1: In HUNT the block compares the last eight strobed chips with the start flag 1,1,1,1,0,0,0,0 (first chip received first). A match moves it to DATA with symbol alignment starting at the next chip. The flag chips, and any chips before them, produce no byte output.
- R2: In DATA each group of four strobed chips with exactly one chip high is a symbol. A high chip in position 0, 1, 2 or 3 (position 0 received first) gives the pair 00, 01, 10 or 11. Pairs fill a byte from bits 1:0 upward. `rx_byte_vld` pulses for one clock, with `rx_byte`, on the clock after the strobe of the byte's last chip.
- R3: Two consecutive all-zero symbols form the stop flag. `rx_eof` pulses for one clock on the clock after the strobe of the final chip, and the block returns to HUNT. `rx_eof` and `rx_byte_vld` are never high together.
- R4: Every complete byte between the start flag and the stop flag is output, including the four trailing CRC bytes, in order of arrival.
- R5: A symbol that is neither one-hot nor all-zero, or a single all-zero symbol followed by a nonzero symbol, sets the frame's illegal-symbol flag. A group that is not one-hot adds no data. A one-hot symbol that follows a single all-zero symbol is still decoded.
- R6: The last four bytes of a frame carry the CRC-32 of the payload, low byte first. The CRC uses polynomial 0x04C11DB7 in bit-reflected form, a preset of all ones and a complemented result. A mismatch sets the CRC error flag.
- R7: The payload length is the number of received bytes minus four. The length error flag is set when the payload length is zero, when it exceeds MAX_LEN, or when the stop flag arrives with a byte partly filled.
- R8: The status bits (`st_rdy`, `st_illegal`, `st_crc_err`, `st_len_err`) take the results of a frame in the same clock as `rx_eof`, with `st_rdy` set. They hold until `stat_rd` clears all four on the next clock. A frame end in the same clock as `stat_rd` takes priority. All outputs are 0 after reset.
- R9: While `tx_busy` is high, strobes are ignored and the receiver returns to HUNT. A partly received frame is discarded with no `rx_eof` and no status change. Byte and end-of-frame outputs stay low in the clock after any clock with `tx_busy` high.
- R10: Changes of `ir_chip` while `chip_stb` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_stb | input | 1 | One-clock strobe marking a valid chip sample |
| ir_chip | input | 1 | Sampled infrared chip, 1 = pulse |
| tx_busy | input | 1 | Local transmitter active; receive disabled |
| stat_rd | input | 1 | Host read of status; clears it |
| rx_byte_vld | output | 1 | Decoded byte valid pulse |
| rx_byte | output | 8 | Decoded byte |
| rx_eof | output | 1 | End-of-frame pulse |
| st_rdy | output | 1 | Status holds results of a completed frame |
| st_illegal | output | 1 | Illegal symbol seen in the frame |
| st_crc_err | output | 1 | CRC-32 mismatch |
| st_len_err | output | 1 | Payload length out of range or partial byte |

## Verification
A byte, an end-of-frame pulse and the status results all become visible in the clock after the strobe that carried the last chip involved. A status read shows its effect one clock after `stat_rd`. The bench drives every input on the falling edge and holds each strobe for exactly one clock. It samples outputs on the next falling edge, so every registered result is read in the clock it is due. A monitor on the falling edge records each one-clock pulse exactly once. The bench inverts the line during the gap clocks between strobes, so a block that wrongly samples between strobes would corrupt every frame.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    localparam int                SYM_LEN     = 4;
    localparam int                FLAG_LEN    = 8;
    localparam logic [FLAG_LEN-1:0] START_FLAG = 8'h0F;   // bit 0 = oldest chip
    localparam logic [31:0]       CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0]       CRC_GOOD    = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_DATA = 2'd1,
        S_ZERO = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic rdy;
        logic len;
        logic crc;
        logic ill;
    } rx_stat_t;
endpackage

// File: rtl/irrx_chip_group.sv
module irrx_chip_group
    import irrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb,
    input  logic               chip,
    input  logic               hunt,
    output logic               start_hit,
    output logic               grp_vld,
    output logic [SYM_LEN-1:0] grp
);
    localparam int HW = FLAG_LEN - 1;
    localparam int CW = $clog2(SYM_LEN);

    logic [HW-1:0]       hist;
    logic [CW-1:0]       cnt;
    logic [FLAG_LEN-1:0] win;

    assign win       = {chip, hist};
    assign start_hit = stb & hunt & (win == START_FLAG);
    assign grp_vld   = stb & ~hunt & (cnt == CW'(SYM_LEN - 1));
    assign grp       = win[FLAG_LEN-1 -: SYM_LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            cnt  <= '0;
        end else if (stb) begin
            hist <= win[FLAG_LEN-1:1];
            cnt  <= hunt ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/irrx_crc32.sv
module irrx_crc32
    import irrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       crc_ok
);
    logic [31:0] crc_q;
    logic [31:0] crc_d;

    always_comb begin
        crc_d = crc_q ^ {24'h0, byte_in};
        for (int i = 0; i < 8; i++) begin
            crc_d = crc_d[0] ? ((crc_d >> 1) ^ CRC_POLY_R) : (crc_d >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        crc_q <= '1;
        else if (init)     crc_q <= '1;
        else if (byte_vld) crc_q <= crc_d;
    end

    assign crc_ok = (crc_q == CRC_GOOD);
endmodule

// File: rtl/irrx_frame_fsm.sv
module irrx_frame_fsm
    import irrx_pkg::*;
#(
    parameter int MAX_LEN = 2050
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start_hit,
    input  logic               grp_vld,
    input  logic [SYM_LEN-1:0] grp,
    input  logic               crc_ok,
    output logic               hunt,
    output logic               crc_init,
    output logic               byte_vld,
    output logic [7:0]         byte_data,
    output logic               eof,
    output logic               done,
    output logic               done_ill,
    output logic               done_crc,
    output logic               done_len
);
    localparam int CNT_MAX = MAX_LEN + 5;
    localparam int CW      = $clog2(CNT_MAX + 1);

    rx_state_e state, state_nx;
    logic [1:0]    pair_cnt;
    logic [7:0]    acc;
    logic [CW-1:0] byte_cnt;
    logic          ill;
    logic          one_hot;
    logic          zero;
    logic [1:0]    pair;

    assign zero    = (grp == '0);
    assign one_hot = !zero && ((grp & (grp - 1'b1)) == '0);

    always_comb begin
        unique case (grp)
            4'b0010: pair = 2'd1;
            4'b0100: pair = 2'd2;
            4'b1000: pair = 2'd3;
            default: pair = 2'd0;
        endcase
    end

    assign hunt     = (state == S_HUNT);
    assign crc_init = start_hit;
    assign done     = !abort && grp_vld && zero && (state == S_ZERO);
    assign done_ill = ill;
    assign done_crc = !crc_ok;
    assign done_len = (pair_cnt != 2'd0) || (byte_cnt <= CW'(4)) ||
                      (byte_cnt > CW'(MAX_LEN + 4));

    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = S_HUNT;                        // ABORT
        end else begin
            unique case (state)
                S_HUNT: if (start_hit)       state_nx = S_DATA;   // START
                S_DATA: if (grp_vld && zero) state_nx = S_ZERO;   // GAP
                S_ZERO: if (grp_vld)         state_nx = zero ? S_HUNT   // STOP
                                                             : S_DATA;  // RESUME
                default:                     state_nx = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_cnt  <= '0;
            acc       <= '0;
            byte_cnt  <= '0;
            ill       <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            eof       <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            eof      <= 1'b0;
            if (abort || start_hit) begin
                pair_cnt <= '0;
                byte_cnt <= '0;
                ill      <= 1'b0;
            end else if (grp_vld && !hunt) begin
                if (done) begin
                    eof <= 1'b1;
                end else if (one_hot) begin
                    if (state == S_ZERO) ill <= 1'b1;
                    acc      <= {pair, acc[7:2]};
                    pair_cnt <= pair_cnt + 1'b1;
                    if (pair_cnt == 2'd3) begin
                        byte_vld  <= 1'b1;
                        byte_data <= {pair, acc[7:2]};
                        if (byte_cnt != CW'(CNT_MAX)) byte_cnt <= byte_cnt + 1'b1;
                    end
                end else if (!zero) begin
                    ill <= 1'b1;
                end
            end
        end
    end

    // R3
    eof_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> !byte_vld);

    // R2
    byte_after_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(grp_vld));
endmodule

// File: rtl/irrx_4ppm.sv
module irrx_4ppm
    import irrx_pkg::*;
#(
    parameter int MAX_LEN = 2050
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_stb,
    input  logic       ir_chip,
    input  logic       tx_busy,
    input  logic       stat_rd,
    output logic       rx_byte_vld,
    output logic [7:0] rx_byte,
    output logic       rx_eof,
    output logic       st_rdy,
    output logic       st_illegal,
    output logic       st_crc_err,
    output logic       st_len_err
);
    logic               stb_q;
    logic               hunt;
    logic               start_hit;
    logic               grp_vld;
    logic [SYM_LEN-1:0] grp;
    logic               crc_init;
    logic               crc_ok;
    logic               done, done_ill, done_crc, done_len;
    rx_stat_t           stat;

    assign stb_q = chip_stb & ~tx_busy;

    irrx_chip_group u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb_q),
        .chip      (ir_chip),
        .hunt      (hunt),
        .start_hit (start_hit),
        .grp_vld   (grp_vld),
        .grp       (grp)
    );

    irrx_frame_fsm #(.MAX_LEN(MAX_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (tx_busy),
        .start_hit (start_hit),
        .grp_vld   (grp_vld),
        .grp       (grp),
        .crc_ok    (crc_ok),
        .hunt      (hunt),
        .crc_init  (crc_init),
        .byte_vld  (rx_byte_vld),
        .byte_data (rx_byte),
        .eof       (rx_eof),
        .done      (done),
        .done_ill  (done_ill),
        .done_crc  (done_crc),
        .done_len  (done_len)
    );

    irrx_crc32 u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (crc_init),
        .byte_vld (rx_byte_vld),
        .byte_in  (rx_byte),
        .crc_ok   (crc_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat <= '0;
        else if (done)    stat <= '{rdy: 1'b1, len: done_len, crc: done_crc, ill: done_ill};
        else if (stat_rd) stat <= '0;
    end

    assign st_rdy     = stat.rdy;
    assign st_illegal = stat.ill;
    assign st_crc_err = stat.crc;
    assign st_len_err = stat.len;

    // R9
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> (!rx_byte_vld && !rx_eof));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done) |=> !st_rdy);

    // R8
    eof_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |-> st_rdy);
endmodule

// File: tb/irrx_4ppm_tb.sv
module irrx_4ppm_tb;
    localparam int MAXL = 260;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_stb = 1'b0, ir_chip = 1'b0, tx_busy = 1'b0, stat_rd = 1'b0;
    logic rx_byte_vld, rx_eof, st_rdy, st_illegal, st_crc_err, st_len_err;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] pay [0:299];
    logic [7:0] expb [0:299];
    logic [7:0] rx [0:299];
    int rx_n = 0;
    int eof_n = 0;

    always #10 clk = ~clk;

    irrx_4ppm #(.MAX_LEN(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .ir_chip(ir_chip),
        .tx_busy(tx_busy), .stat_rd(stat_rd), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_eof(rx_eof), .st_rdy(st_rdy),
        .st_illegal(st_illegal), .st_crc_err(st_crc_err), .st_len_err(st_len_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_byte_vld) begin
            if (rx_n < 300) rx[rx_n] = rx_byte;
            rx_n++;
        end
        if (rst_n && rx_eof) eof_n++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc32(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, pay[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // R10: line toggles during the gap clock
    task automatic send_chip(input logic b);
        chip_stb = 1'b1; ir_chip = b;
        @(negedge clk);
        chip_stb = 1'b0; ir_chip = ~b;
        @(negedge clk);
    endtask

    task automatic send_group(input logic [3:0] g);
        for (int k = 0; k < 4; k++) send_chip(g[k]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int p = 0; p < 4; p++) send_group(4'b0001 << b[2*p +: 2]);
    endtask

    task automatic send_start();
        for (int k = 0; k < 8; k++) send_chip(k < 4);
    endtask

    // mode: 0 plain, 1 illegal group, 2 lone zero group before a symbol
    task automatic send_frame(input int n, input bit bad_crc, input int mode, input bit extra);
        logic [31:0] c;
        c = crc32(n);
        if (bad_crc) c ^= 32'h1;
        rx_n = 0; eof_n = 0;
        send_start();
        for (int i = 0; i < n; i++) begin
            if (i == 0 && mode == 1) send_group(4'b0110);
            if (i == 0 && mode == 2) send_group(4'b0000);
            send_byte(pay[i]);
            expb[i] = pay[i];
        end
        for (int j = 0; j < 4; j++) begin
            send_byte(c[8*j +: 8]);
            expb[n+j] = c[8*j +: 8];
        end
        if (extra) send_group(4'b0001);
        send_group(4'b0000);
        send_group(4'b0000);
    endtask

    task automatic check_frame(input string req, input int n, input bit ill, input bit crc, input bit len);
        int bad = 0;
        check({req, " byte count"}, rx_n, n + 4);
        for (int i = 0; i < n + 4 && i < rx_n && i < 300; i++) begin
            checks++;
            if (rx[i] !== expb[i]) begin
                errors++; bad++;
                if (bad < 5) $display("FAIL %s byte %0d actual=%0h expected=%0h", req, i, rx[i], expb[i]);
            end
        end
        check({req, " eof"}, eof_n, 1);
        check({req, " status"}, {st_rdy, st_illegal, st_crc_err, st_len_err}, {1'b1, ill, crc, len});
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset outputs", {rx_byte_vld, rx_eof, st_rdy, st_illegal, st_crc_err, st_len_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: noise without a start flag gives nothing
        rx_n = 0; eof_n = 0;
        for (int r = 0; r < 6; r++) send_group(4'b1011 ^ r[3:0]);
        for (int r = 0; r < 4; r++) begin send_group(4'b1101); send_group(4'b0100); end
        check("R1 noise gives no byte", rx_n, 0);
        check("R1 noise gives no eof", eof_n, 0);

        // R1 R2 R4 R6 R10: every byte value once
        for (int i = 0; i < 256; i++) pay[i] = i[7:0];
        send_frame(256, 0, 0, 0);
        check_frame("R2 R4 all symbols", 256, 0, 0, 0);
        check("R1 flag not output", rx[0], 8'h00);
        read_status();
        // R8: read clears
        check("R8 read clears", {st_rdy, st_illegal, st_crc_err, st_len_err}, 4'h0);

        // R2 R6: short frames
        for (int n = 1; n <= 5; n++) begin
            for (int i = 0; i < n; i++) pay[i] = 8'(i * 37 + n * 11);
            send_frame(n, 0, 0, 0);
            check_frame("R2 R6 short frame", n, 0, 0, 0);
            read_status();
        end

        // R6: CRC error
        for (int i = 0; i < 3; i++) pay[i] = 8'(8'hA5 + i);
        send_frame(3, 1, 0, 0);
        check_frame("R6 crc error", 3, 0, 1, 0);
        // R8: next frame end overwrites without read
        send_frame(3, 0, 0, 0);
        check_frame("R8 status overwrite", 3, 0, 0, 0);
        read_status();

        // R5: illegal group dropped, lone zero group then a symbol decoded
        send_frame(3, 0, 1, 0);
        check_frame("R5 illegal group", 3, 1, 0, 0);
        read_status();
        send_frame(3, 0, 2, 0);
        check_frame("R5 lone zero group", 3, 1, 0, 0);
        read_status();

        // R7: length bounds
        send_frame(0, 0, 0, 0);
        check_frame("R7 empty payload", 0, 0, 0, 1);
        read_status();
        for (int i = 0; i < MAXL + 1; i++) pay[i] = 8'(i * 7);
        send_frame(MAXL, 0, 0, 0);
        check_frame("R7 max length", MAXL, 0, 0, 0);
        read_status();
        send_frame(MAXL + 1, 0, 0, 0);
        check_frame("R7 over max", MAXL + 1, 0, 0, 1);
        read_status();
        send_frame(2, 0, 0, 1);
        check_frame("R7 partial byte", 2, 0, 0, 1);
        read_status();

        // R9: transmitter active aborts the frame
        rx_n = 0; eof_n = 0;
        send_start();
        send_byte(8'h3C);
        tx_busy = 1'b1;
        send_byte(8'h5A);
        send_group(4'b0000);
        send_group(4'b0000);
        tx_busy = 1'b0;
        send_group(4'b0000);
        send_group(4'b0000);
        check("R9 bytes before abort only", rx_n, 1);
        check("R9 no eof", eof_n, 0);
        check("R9 status untouched", {st_rdy, st_illegal, st_crc_err, st_len_err}, 4'h0);
        pay[0] = 8'hC3;
        send_frame(1, 0, 0, 0);
        check_frame("R9 recovers", 1, 0, 0, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule